// File: doc/BRIEF.md
# Pipeline Exception Redirect Controller

This block sits beside the hazard logic of a five-stage in-order pipeline and turns three exception sources into one redirect. The sources are an arithmetic overflow reported by the execute stage, an undefined opcode reported by the decode stage, and an external interrupt line. When one of them is accepted, the block does three things in the same cycle. It points the fetch unit at a fixed handler address. It drops the instruction held in the fetch/decode register. It zeroes the control bits of the instructions that must not complete, so that none of them can write the register file or data memory. Instructions already in the memory and write-back stages are older, and they finish normally.

On the clock edge that ends the accepting cycle, the block captures two values. The first is the address of the instruction to blame or resume, taken as the stage's PC+4 minus 4. The second is a cause code. The fetch unit loads the handler address on that same edge, so the first handler instruction is fetched in the cycle after detection. For one cycle after a redirect the block ignores new requests, because the pipeline is still refilling.

Top module: `exc_redirect_ctrl`

## Requirements
- R1: After reset the captured address and the cause code read 0, and no redirect, flush or squash output is asserted.
- R2: An overflow flagged by a valid execute-stage instruction asserts redirect, the flush of fetch/decode, the decode squash and the execute squash in that same cycle. The redirect target is 0x8000_0180.
- R3: On the clock edge after an accepted overflow, the captured address becomes the execute-stage PC+4 minus 4 and the cause code becomes 12.
- R4: An overflow flag whose execute-stage valid bit is low has no effect: there is no redirect and the captured address and cause keep their values.
- R5: An undefined opcode flagged by a valid decode-stage instruction redirects and flushes and squashes decode, but does not squash execute. The captured address then becomes the decode-stage PC+4 minus 4 and the cause code becomes 10.
- R6: The interrupt line redirects with the same flush and decode squash as R5 and no execute squash. It captures the decode-stage PC+4 minus 4 and cause code 0.
- R7: When several requests occur together, overflow wins over undefined opcode, and undefined opcode wins over interrupt.
- R8: In the cycle directly after a redirect every request is ignored, with no redirect and no change to the captured values. The same request is accepted one cycle later.
- R9: While no request is active, all redirect, flush and squash outputs stay low and the captured address and cause hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_ovf | input | 1 | Execute-stage arithmetic overflow |
| ex_pc_plus4 | input | 32 | PC+4 of the execute-stage instruction |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_undef | input | 1 | Decode-stage opcode is undefined |
| id_pc_plus4 | input | 32 | PC+4 of the decode-stage instruction |
| irq | input | 1 | External interrupt request |
| redirect | output | 1 | Load redirect_pc into the PC on the next edge |
| redirect_pc | output | 32 | Handler address while redirect is high, else 0 |
| flush_ifid | output | 1 | Drop the fetch/decode register contents |
| squash_id | output | 1 | Zero the decode-stage control bits |
| squash_ex | output | 1 | Zero the execute-stage control bits |
| epc | output | 32 | Captured instruction address |
| cause | output | 5 | Captured cause code |

## Verification
The sources are applied one at a time, so that each cause code, captured address and execute-squash setting can be tied to its source. An overflow flag with a low valid bit and an undefined flag with a low valid bit show that the qualifiers gate the requests. The sources are also applied in combination: all three together, decode plus interrupt, and an invalid overflow plus interrupt. These separate the priority order from plain OR-ing of the requests. Back-to-back requests show the one-cycle lockout and the acceptance that follows it, and an idle stretch shows that the captured values hold.

// File: rtl/exc_redirect_pkg.sv
package exc_redirect_pkg;
    localparam int XLEN    = 32;
    localparam int CAUSE_W = 5;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_OVF   = 2'd1,
        SRC_UNDEF = 2'd2,
        SRC_IRQ   = 2'd3
    } exc_src_e;

    localparam logic [CAUSE_W-1:0] CODE_OVF   = 5'd12;
    localparam logic [CAUSE_W-1:0] CODE_UNDEF = 5'd10;
    localparam logic [CAUSE_W-1:0] CODE_IRQ   = 5'd0;
endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
    import exc_redirect_pkg::*;
(
    input  logic     ovf_req,
    input  logic     undef_req,
    input  logic     irq_req,
    input  logic     blocked,
    output exc_src_e src
);
    // Fixed order: execute overflow, then decode undefined, then interrupt.
    always_comb begin
        if (blocked)        src = SRC_NONE;
        else if (ovf_req)   src = SRC_OVF;
        else if (undef_req) src = SRC_UNDEF;
        else if (irq_req)   src = SRC_IRQ;
        else                src = SRC_NONE;
    end
endmodule

// File: rtl/exc_cause_regs.sv
module exc_cause_regs
    import exc_redirect_pkg::*;
#(
    parameter int AW = XLEN,
    parameter int CW = CAUSE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  exc_src_e      src,
    input  logic [AW-1:0] ex_pc4,
    input  logic [AW-1:0] id_pc4,
    output logic [AW-1:0] epc_o,
    output logic [CW-1:0] cause_o,
    output logic          busy_o
);
    localparam logic [AW-1:0] INSN_BYTES = AW'(4);

    typedef struct packed {
        logic          busy;
        logic [AW-1:0] epc;
        logic [CW-1:0] cause;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.busy = (src != SRC_NONE);
        unique case (src)
            SRC_OVF: begin
                st_d.epc   = ex_pc4 - INSN_BYTES;
                st_d.cause = CW'(CODE_OVF);
            end
            SRC_UNDEF: begin
                st_d.epc   = id_pc4 - INSN_BYTES;
                st_d.cause = CW'(CODE_UNDEF);
            end
            SRC_IRQ: begin
                st_d.epc   = id_pc4 - INSN_BYTES;
                st_d.cause = CW'(CODE_IRQ);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign epc_o   = st_q.epc;
    assign cause_o = st_q.cause;
    assign busy_o  = st_q.busy;

    // R3: overflow capture lands on the next edge
    assert_capture_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_OVF) |=> (cause_o == CW'(CODE_OVF)) && (epc_o == $past(ex_pc4) - INSN_BYTES));

    // R9: captured values hold when nothing is accepted
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_NONE) |=> $stable(epc_o) && $stable(cause_o));
endmodule

// File: rtl/exc_redirect_ctrl.sv
module exc_redirect_ctrl
    import exc_redirect_pkg::*;
#(
    parameter int          AW     = XLEN,
    parameter int          CW     = CAUSE_W,
    parameter logic [31:0] VECTOR = 32'h8000_0180
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ex_valid,
    input  logic          ex_ovf,
    input  logic [AW-1:0] ex_pc_plus4,
    input  logic          id_valid,
    input  logic          id_undef,
    input  logic [AW-1:0] id_pc_plus4,
    input  logic          irq,
    output logic          redirect,
    output logic [AW-1:0] redirect_pc,
    output logic          flush_ifid,
    output logic          squash_id,
    output logic          squash_ex,
    output logic [AW-1:0] epc,
    output logic [CW-1:0] cause
);
    localparam logic [AW-1:0] HANDLER = AW'(VECTOR);

    logic     ovf_req, undef_req, busy;
    exc_src_e src;

    assign ovf_req   = ex_valid & ex_ovf;
    assign undef_req = id_valid & id_undef;

    exc_prio_sel u_prio (
        .ovf_req   (ovf_req),
        .undef_req (undef_req),
        .irq_req   (irq),
        .blocked   (busy),
        .src       (src)
    );

    exc_cause_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (src),
        .ex_pc4  (ex_pc_plus4),
        .id_pc4  (id_pc_plus4),
        .epc_o   (epc),
        .cause_o (cause),
        .busy_o  (busy)
    );

    always_comb begin
        redirect    = (src != SRC_NONE);
        redirect_pc = redirect ? HANDLER : '0;
        flush_ifid  = redirect;
        squash_id   = redirect;
        squash_ex   = (src == SRC_OVF);
    end

    // R2: every redirect flushes fetch/decode and squashes decode toward the vector
    assert_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> flush_ifid && squash_id && (redirect_pc == HANDLER));

    // R7: an accepted overflow always squashes execute, regardless of other requests
    assert_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_ovf && !busy) |-> squash_ex && redirect);

    // R8: no back-to-back redirects
    assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !redirect);

    // R4: an unqualified overflow alone never redirects
    assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_valid && !(id_valid && id_undef) && !irq) |-> !redirect && !squash_ex);
endmodule

// File: tb/sim_exc_redirect_ctrl.sv
module sim_exc_redirect_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ex_valid, ex_ovf, id_valid, id_undef, irq;
    logic [31:0] ex_pc_plus4, id_pc_plus4;
    logic        redirect, flush_ifid, squash_id, squash_ex;
    logic [31:0] redirect_pc, epc;
    logic [4:0]  cause;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    exc_redirect_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .ex_valid(ex_valid), .ex_ovf(ex_ovf), .ex_pc_plus4(ex_pc_plus4),
        .id_valid(id_valid), .id_undef(id_undef), .id_pc_plus4(id_pc_plus4),
        .irq(irq), .redirect(redirect), .redirect_pc(redirect_pc),
        .flush_ifid(flush_ifid), .squash_id(squash_id), .squash_ex(squash_ex),
        .epc(epc), .cause(cause)
    );

    typedef struct packed {
        logic        ev, eo;
        logic [31:0] epc4;
        logic        iv, iu;
        logic [31:0] ipc4;
        logic        rq;
        logic        xr, xs;
        logic [4:0]  xc;
        logic [31:0] xepc;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,32'h104, 1'b0,1'b0,32'h0,   1'b0, 1'b1,1'b1,5'd12,32'h100}, // R2 R3
        '{1'b0,1'b1,32'h154, 1'b0,1'b0,32'h0,   1'b0, 1'b0,1'b0,5'd12,32'h100}, // R4
        '{1'b0,1'b0,32'h0,   1'b1,1'b1,32'h208, 1'b0, 1'b1,1'b0,5'd10,32'h204}, // R5
        '{1'b0,1'b0,32'h0,   1'b0,1'b0,32'h30C, 1'b1, 1'b1,1'b0,5'd0, 32'h308}, // R6
        '{1'b1,1'b1,32'h404, 1'b1,1'b1,32'h408, 1'b1, 1'b1,1'b1,5'd12,32'h400}, // R7
        '{1'b0,1'b0,32'h0,   1'b1,1'b1,32'h50C, 1'b1, 1'b1,1'b0,5'd10,32'h508}, // R7
        '{1'b0,1'b0,32'h0,   1'b0,1'b1,32'h55C, 1'b0, 1'b0,1'b0,5'd10,32'h508}, // R9
        '{1'b0,1'b1,32'h5A4, 1'b0,1'b0,32'h60C, 1'b1, 1'b1,1'b0,5'd0, 32'h608}  // R7
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_idle();
        ex_valid = 0; ex_ovf = 0; ex_pc_plus4 = 0;
        id_valid = 0; id_undef = 0; id_pc_plus4 = 0; irq = 0;
    endtask

    task automatic drive_vec(input vec_t v);
        ex_valid = v.ev; ex_ovf = v.eo; ex_pc_plus4 = v.epc4;
        id_valid = v.iv; id_undef = v.iu; id_pc_plus4 = v.ipc4; irq = v.rq;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        drive_idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state
        check("R1 epc", epc, 32'h0);
        check("R1 cause", {27'b0, cause}, 32'h0);
        check("R1 redirect", {31'b0, redirect}, 32'h0);
        check("R1 squash", {30'b0, squash_id, squash_ex}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive_vec(VECS[i]);
            #1;
            check($sformatf("R2/R5/R6/R7 vec%0d redirect", i), {31'b0, redirect}, {31'b0, VECS[i].xr});
            check($sformatf("R2 vec%0d flush", i), {30'b0, flush_ifid, squash_id}, {30'b0, VECS[i].xr, VECS[i].xr});
            check($sformatf("R2/R7 vec%0d squash_ex", i), {31'b0, squash_ex}, {31'b0, VECS[i].xs});
            check($sformatf("R2 vec%0d target", i), redirect_pc, VECS[i].xr ? 32'h8000_0180 : 32'h0);
            @(posedge clk);
            #1;
            drive_idle();
            check($sformatf("R3/R4/R5/R6/R9 vec%0d cause", i), {27'b0, cause}, {27'b0, VECS[i].xc});
            check($sformatf("R3/R4/R5/R6/R9 vec%0d epc", i), epc, VECS[i].xepc);
            @(posedge clk);
        end

        // R8: request in the cycle right after a redirect is ignored, then accepted
        @(negedge clk);
        ex_valid = 1; ex_ovf = 1; ex_pc_plus4 = 32'h704;
        @(posedge clk); #1;
        drive_idle();
        id_valid = 1; id_undef = 1; id_pc_plus4 = 32'h808;
        #1;
        check("R8 lockout redirect", {31'b0, redirect}, 32'h0);
        check("R8 capture from overflow", epc, 32'h700);
        @(posedge clk); #1;
        check("R8 unchanged cause", {27'b0, cause}, 32'd12);
        check("R8 unchanged epc", epc, 32'h700);
        check("R8 accepted after lockout", {31'b0, redirect}, 32'h1);
        @(posedge clk); #1;
        drive_idle();
        check("R8 later cause", {27'b0, cause}, 32'd10);
        check("R8 later epc", epc, 32'h804);

        // R9: idle stretch holds state
        repeat (4) @(posedge clk);
        #1;
        check("R9 idle redirect", {31'b0, redirect}, 32'h0);
        check("R9 idle epc", epc, 32'h804);
        check("R9 idle cause", {27'b0, cause}, 32'd10);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule